// File: doc/BRIEF.md
# SMBus Block Transfer Data Engine

This block is the data side of an SMBus host controller for block transfers. Software loads or unloads the payload through one data port. The engine passes bytes to and from a byte-level link sequencer through a request and done handshake. The link sequencer handles the wire signalling. The block also keeps the byte count register, the command register used by I2C-style block reads, and the byte-done flag.

There are two modes, chosen by `buf_mode`. With `buf_mode` high, a 32-entry store sits behind the data port. Each port access moves an internal pointer forward by one, and a read of the control register returns that pointer to zero. The whole transfer then runs without software help. With `buf_mode` low, the port is a single holding register. The engine pauses after every payload byte, raises `byte_done`, and waits for software to service the port and acknowledge. A control write whose code has bit 5 set marks the next received byte as the last one.

For block transfers the first byte on the link is the byte count. For I2C-style block reads no count is exchanged: the command byte comes from the second data register, the address phase goes out as a write, and the engine always runs byte by byte.

Top module: `smbus_blk_engine`

## Requirements
- R1: After reset, `busy`, `byte_done`, `cnt_err` and `lnk_req` are low, and `dat0_q` and `blk_rdata` read 0.
- R2: With `buf_mode` high, each `blk_wr` stores `wdata` at the pointer and advances it. A start with `host_rnw` low then sends `dat0_q` followed by the stored bytes in order. The transfer completes with `busy` low and without ever raising `byte_done`.
- R3: In a buffered block read, the first received byte is loaded into `dat0_q` and that many following bytes are stored. After a `ctl_rd`, port reads return those bytes in arrival order. `lnk_nack` is high only on the final payload byte.
- R4: A count is valid from 1 to 32. A received count outside this range sets `cnt_err`, drops `busy`, and requests no further bytes. A block write started with an invalid `dat0_q` sets `cnt_err` and makes no link request. The next accepted start clears `cnt_err`.
- R5: `ctl_rd` returns the pointer to 0. If `ctl_rd` and `blk_rd` fall in the same cycle, the read returns the entry at the old pointer and the pointer ends at 0.
- R6: With `buf_mode` high, writes at pointer 32 or above are dropped. Reads at a pointer not below `dat0_q` return 0.
- R7: With `buf_mode` low, `byte_done` rises after each payload byte. It stays high, and no link request is made, until `bd_clr` is pulsed. A `blk_wr` in the same cycle as `bd_clr` supplies the next byte to be sent.
- R8: In an unbuffered block read, `dat0_q` already holds the received count when the first `byte_done` rises. While `byte_done` is high, the port returns the byte just received.
- R9: `ctl_code` bit 5 set (codes 0x34 and 0x38) marks the next received byte as last. A `ctl_wr` without bit 6 updates this mark during a transfer. The marked byte is sent with `lnk_nack` high, and the transfer ends at its `bd_clr`.
- R10: A start is accepted on `ctl_wr` in idle when bit 6 of `ctl_code` is set, bits 1:0 are 0, and bits 4:2 are 101 (block, 0x14) or 110 (I2C-style block, 0x18). An I2C-style read sends no count, drives `lnk_rw` low, presents `dat1` on `lnk_cmd`, and runs byte by byte even when `buf_mode` is high.
- R11: With `buf_mode` low, the port is one register. Reads return the last written byte and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| buf_mode | input | 1 | 32-entry store enable |
| host_rnw | input | 1 | Direction of the next transfer, 1 = read |
| host_cmd | input | 8 | Command byte for block transfers |
| ctl_wr | input | 1 | Control code write strobe |
| ctl_code | input | 7 | Control code: bit 6 start, bit 5 last, bits 4:2 kind |
| ctl_rd | input | 1 | Control register read strobe; clears the pointer |
| dat0_wr | input | 1 | Count register write strobe |
| dat1_wr | input | 1 | Second data register write strobe |
| wdata | input | 8 | Write data shared by all strobes |
| blk_wr | input | 1 | Data port write strobe |
| blk_rd | input | 1 | Data port read strobe |
| blk_rdata | output | 8 | Data port read value |
| dat0_q | output | 8 | Count register |
| bd_clr | input | 1 | Byte-done acknowledge |
| byte_done | output | 1 | Byte serviced flag |
| busy | output | 1 | Transfer in progress |
| cnt_err | output | 1 | Invalid count seen |
| lnk_req | output | 1 | Byte transfer request to the link |
| lnk_rw | output | 1 | Address phase direction bit |
| lnk_cmd | output | 8 | Command byte for the link |
| lnk_tx | output | 8 | Byte to send |
| lnk_nack | output | 1 | Do not acknowledge the byte being received |
| lnk_done | input | 1 | Link finished the requested byte |
| lnk_rx | input | 8 | Received byte, valid with lnk_done |

## Verification
Two events can hit the single holding register in the same cycle: the byte-done acknowledge and a software port write. The bench drives unbuffered writes in which every acknowledge arrives together with the next payload byte. The link-side log must show each new byte on the wire, never the previous contents. The pointer has a similar collision, where the control register read and a port read share one cycle. That case is judged by the byte returned, which must be the old entry, and by the next read, which must return entry 0.

// File: rtl/smbus_blk_engine.sv
module smbus_blk_engine #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode,
  input  logic          host_rnw,
  input  logic [DW-1:0] host_cmd,
  input  logic          ctl_wr,
  input  logic [6:0]    ctl_code,
  input  logic          ctl_rd,
  input  logic          dat0_wr,
  input  logic          dat1_wr,
  input  logic [DW-1:0] wdata,
  input  logic          blk_wr,
  input  logic          blk_rd,
  output logic [DW-1:0] blk_rdata,
  output logic [DW-1:0] dat0_q,
  input  logic          bd_clr,
  output logic          byte_done,
  output logic          busy,
  output logic          cnt_err,
  output logic          lnk_req,
  output logic          lnk_rw,
  output logic [DW-1:0] lnk_cmd,
  output logic [DW-1:0] lnk_tx,
  output logic          lnk_nack,
  input  logic          lnk_done,
  input  logic [DW-1:0] lnk_rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT} st_t;
  st_t st;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dat1, hold;
  logic [IW-1:0] idx, pos;
  logic hdr, rnw_q, i2c_q, bufm, last_q, fin;

  function automatic logic cnt_ok(input logic [DW-1:0] c);
    return (c != '0) && (c <= DW'(DEPTH));
  endfunction

  wire is_i2c   = ctl_code[4:2] == 3'b110;
  wire kind_ok  = (ctl_code[4:2] == 3'b101) || is_i2c;
  wire go       = ctl_wr && ctl_code[6] && kind_ok && (ctl_code[1:0] == 2'b00);
  wire port_buf = buf_mode && !(busy && i2c_q);
  wire at_end   = DW'(pos + 1'b1) == dat0_q;
  wire rd_hit   = (idx < IW'(DEPTH)) && (DW'(idx) < dat0_q);

  assign busy      = st != S_IDLE;
  assign lnk_req   = st == S_XFER;
  assign lnk_rw    = rnw_q && !i2c_q;
  assign lnk_cmd   = i2c_q ? dat1 : host_cmd;
  assign lnk_tx    = hdr ? dat0_q : (bufm ? mem[pos[AW-1:0]] : hold);
  assign lnk_nack  = lnk_req && rnw_q && !hdr && (bufm ? at_end : last_q);
  assign blk_rdata = port_buf ? (rd_hit ? mem[idx[AW-1:0]] : '0) : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      dat0_q <= '0;
      dat1 <= '0;
      hold <= '0;
      idx <= '0;
      pos <= '0;
      hdr <= 1'b0;
      rnw_q <= 1'b0;
      i2c_q <= 1'b0;
      bufm <= 1'b0;
      last_q <= 1'b0;
      fin <= 1'b0;
      byte_done <= 1'b0;
      cnt_err <= 1'b0;
    end else begin
      if (dat0_wr) dat0_q <= wdata;
      if (dat1_wr) dat1 <= wdata;
      if (ctl_wr) last_q <= ctl_code[5];

      if (blk_wr) begin
        if (!port_buf) hold <= wdata;
        else if (idx < IW'(DEPTH)) mem[idx[AW-1:0]] <= wdata;
      end
      if (ctl_rd) idx <= '0;
      else if ((blk_wr || blk_rd) && port_buf && idx != IW'(DEPTH)) idx <= idx + 1'b1;

      case (st)
        S_IDLE: if (go) begin
          i2c_q <= is_i2c;
          rnw_q <= host_rnw;
          bufm <= buf_mode && !is_i2c;
          hdr <= !is_i2c;
          pos <= '0;
          cnt_err <= 1'b0;
          if (!host_rnw && !cnt_ok(dat0_q)) cnt_err <= 1'b1;
          else st <= S_XFER;
        end
        S_XFER: if (lnk_done) begin
          if (hdr) begin
            hdr <= 1'b0;
            if (rnw_q) begin
              dat0_q <= lnk_rx;
              if (!cnt_ok(lnk_rx)) begin
                cnt_err <= 1'b1;
                st <= S_IDLE;
              end
            end
          end else begin
            pos <= pos + 1'b1;
            if (rnw_q) begin
              if (bufm) mem[pos[AW-1:0]] <= lnk_rx;
              else hold <= lnk_rx;
            end
            if (bufm) begin
              if (at_end) st <= S_IDLE;
            end else begin
              byte_done <= 1'b1;
              fin <= rnw_q ? last_q : at_end;
              st <= S_WAIT;
            end
          end
        end
        S_WAIT: if (bd_clr) begin
          byte_done <= 1'b0;
          st <= fin ? S_IDLE : S_XFER;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smbus_blk_engine_chk.sv
module smbus_blk_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_done,
  input logic bd_clr,
  input logic busy,
  input logic cnt_err,
  input logic lnk_req,
  input logic lnk_nack,
  input logic lnk_done
);
  // R7
  bd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !bd_clr |=> byte_done);
  // R7
  bd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && bd_clr |=> !byte_done);
  // R7
  bd_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !lnk_req);
  // R2
  bd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> busy);
  // R9
  nack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_nack |-> lnk_req);
  // R4
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_err) |-> !busy && !lnk_req);
  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_req && !lnk_done |=> lnk_req);
endmodule

bind smbus_blk_engine smbus_blk_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .bd_clr(bd_clr),
  .busy(busy), .cnt_err(cnt_err), .lnk_req(lnk_req), .lnk_nack(lnk_nack),
  .lnk_done(lnk_done)
);

// File: tb/sim_smbus_blk_engine.sv
`timescale 1ns/1ps
module sim_smbus_blk_engine;
  logic clk = 0, rst_n = 0;
  logic buf_mode = 0, host_rnw = 0, ctl_wr = 0, ctl_rd = 0, dat0_wr = 0, dat1_wr = 0;
  logic blk_wr = 0, blk_rd = 0, bd_clr = 0, lnk_done = 0;
  logic [7:0] host_cmd = 8'h11, wdata = 0, lnk_rx = 0;
  logic [6:0] ctl_code = 0;
  logic [7:0] blk_rdata, dat0_q, lnk_cmd, lnk_tx;
  logic byte_done, busy, cnt_err, lnk_req, lnk_rw, lnk_nack;

  always #5 clk = ~clk;

  smbus_blk_engine u0 (.*);

  int nchk = 0, nfail = 0;
  logic [7:0] tx_log [64];
  logic nack_log [64];
  logic [7:0] rx_src [64];
  logic rw_log;
  logic [7:0] cmd_log;
  int nlog = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      lnk_done = 0;
      if (lnk_req) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        tx_log[nlog] = lnk_tx;
        nack_log[nlog] = lnk_nack;
        rw_log = lnk_rw;
        cmd_log = lnk_cmd;
        lnk_rx = rx_src[nlog];
        nlog++;
        lnk_done = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr0(input logic [7:0] v); wdata = v; dat0_wr = 1; tick(); dat0_wr = 0; endtask
  task automatic wr1(input logic [7:0] v); wdata = v; dat1_wr = 1; tick(); dat1_wr = 0; endtask
  task automatic bw(input logic [7:0] v); wdata = v; blk_wr = 1; tick(); blk_wr = 0; endtask
  task automatic br(output logic [7:0] v); blk_rd = 1; #1 v = blk_rdata; tick(); blk_rd = 0; endtask
  task automatic ctl(input logic [6:0] c); ctl_code = c; ctl_wr = 1; tick(); ctl_wr = 0; endtask
  task automatic crd(); ctl_rd = 1; tick(); ctl_rd = 0; endtask
  task automatic clr(); bd_clr = 1; tick(); bd_clr = 0; endtask
  task automatic clr_wr(input logic [7:0] v);
    wdata = v; blk_wr = 1; bd_clr = 1; tick(); blk_wr = 0; bd_clr = 0;
  endtask
  task automatic wait_bd(input string tag);
    int n = 0;
    while (!byte_done && n < 200) begin tick(); n++; end
    chk(byte_done, tag, byte_done, 1);
  endtask
  task automatic wait_idle(input string tag);
    int n = 0;
    tick();
    while (busy && n < 500) begin tick(); n++; end
    chk(!busy, tag, busy, 0);
    tick(); tick();
  endtask

  logic [7:0] b [40];
  logic [7:0] v;

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) tick();
    // R1
    chk(!busy && !byte_done && !cnt_err && !lnk_req, "R1 flags", {busy, byte_done, cnt_err, lnk_req}, 0);
    chk(dat0_q == 0 && blk_rdata == 0, "R1 regs", {dat0_q, blk_rdata}, 0);
    rst_n = 1;
    tick();

    // R2: buffered writes, random lengths
    buf_mode = 1; host_rnw = 0;
    for (int it = 0; it < 3; it++) begin
      int n = (it == 0) ? 32 : $urandom_range(1, 31);
      nlog = 0;
      crd(); wr0(8'(n));
      for (int k = 0; k < n; k++) begin b[k] = 8'($urandom); bw(b[k]); end
      ctl(7'h54);
      wait_idle("R2 end");
      chk(nlog == n + 1, "R2 byte count", nlog, n + 1);
      chk(tx_log[0] == 8'(n), "R2 count byte", tx_log[0], n);
      for (int k = 0; k < n; k++)
        chk(tx_log[k+1] == b[k], "R2 data", tx_log[k+1], b[k]);
      chk(!byte_done, "R2 no byte_done", byte_done, 0);
    end

    // R3: buffered reads
    host_rnw = 1;
    for (int it = 0; it < 2; it++) begin
      int n = (it == 0) ? 32 : $urandom_range(1, 31);
      nlog = 0;
      rx_src[0] = 8'(n);
      for (int k = 0; k < n; k++) begin b[k] = 8'($urandom); rx_src[k+1] = b[k]; end
      ctl(7'h54);
      wait_idle("R3 end");
      chk(dat0_q == 8'(n), "R3 count in dat0", dat0_q, n);
      crd();
      for (int k = 0; k < n; k++) begin br(v); chk(v == b[k], "R3 readback", v, b[k]); end
      for (int k = 1; k <= n; k++)
        chk(nack_log[k] == (k == n), "R3 nack", nack_log[k], k == n);
      // R6
      br(v); chk(v == 0, "R6 read past count", v, 0);
    end

    // R6: overflow writes
    crd(); wr0(8'd32);
    for (int k = 0; k < 34; k++) begin b[k] = 8'($urandom); bw(b[k]); end
    crd();
    for (int k = 0; k < 32; k++) begin br(v); chk(v == b[k], "R6 keep first 32", v, b[k]); end
    br(v); chk(v == 0, "R6 beyond end", v, 0);

    // R5: same-cycle control read and port read
    crd(); br(v); br(v);
    ctl_rd = 1; blk_rd = 1; #1 v = blk_rdata; tick(); ctl_rd = 0; blk_rd = 0;
    chk(v == b[2], "R5 old entry", v, b[2]);
    br(v); chk(v == b[0], "R5 pointer cleared", v, b[0]);

    // R4: invalid counts
    nlog = 0; host_rnw = 1; rx_src[0] = 8'd0;
    ctl(7'h54); wait_idle("R4 end");
    chk(cnt_err && nlog == 1, "R4 zero count", {cnt_err, 8'(nlog)}, 9'h101);
    nlog = 0; buf_mode = 0; rx_src[0] = 8'd33;
    ctl(7'h54); wait_idle("R4 end2");
    chk(cnt_err && nlog == 1 && !byte_done, "R4 count 33", {cnt_err, 8'(nlog)}, 9'h101);
    nlog = 0; host_rnw = 0; wr0(8'd0);
    ctl(7'h54); tick(); tick(); tick();
    chk(cnt_err && !busy && nlog == 0, "R4 write zero", {cnt_err, busy, 8'(nlog)}, 10'h200);

    // R7: unbuffered write, acknowledge together with next byte
    nlog = 0; wr0(8'd4);
    for (int k = 0; k < 4; k++) b[k] = 8'($urandom);
    bw(b[0]); ctl(7'h54);
    chk(!cnt_err, "R4 cleared by start", cnt_err, 0);
    for (int k = 0; k < 4; k++) begin
      wait_bd("R7 byte_done");
      tick(); tick(); tick();
      chk(nlog == k + 2 && byte_done, "R7 stall", nlog, k + 2);
      if (k < 3) clr_wr(b[k+1]); else clr();
    end
    wait_idle("R7 end");
    chk(tx_log[0] == 8'd4, "R7 count byte", tx_log[0], 4);
    for (int k = 0; k < 4; k++)
      chk(tx_log[k+1] == b[k], "R7 same-cycle data", tx_log[k+1], b[k]);

    // R8 / R9: unbuffered block read with last mark
    nlog = 0; host_rnw = 1; rx_src[0] = 8'd3;
    for (int k = 0; k < 3; k++) begin b[k] = 8'($urandom); rx_src[k+1] = b[k]; end
    ctl(7'h54);
    for (int k = 0; k < 3; k++) begin
      wait_bd("R8 byte_done");
      if (k == 0) chk(dat0_q == 8'd3, "R8 count before first done", dat0_q, 3);
      chk(blk_rdata == b[k], "R8 port data", blk_rdata, b[k]);
      if (k == 1) ctl(7'h34);
      clr();
    end
    wait_idle("R9 end");
    chk(nlog == 4, "R9 stop after last", nlog, 4);
    for (int k = 1; k <= 3; k++)
      chk(nack_log[k] == (k == 3), "R9 nack", nack_log[k], k == 3);

    // R10: I2C-style read with buffer mode high
    buf_mode = 1; nlog = 0; wr1(8'h5A);
    rx_src[0] = 8'h9C; rx_src[1] = 8'h27;
    ctl(7'h58);
    wait_bd("R10 first");
    chk(blk_rdata == 8'h9C && rw_log == 0 && cmd_log == 8'h5A, "R10 first byte",
        {blk_rdata, rw_log, cmd_log}, {8'h9C, 1'b0, 8'h5A});
    ctl(7'h38); clr();
    wait_bd("R10 second");
    chk(blk_rdata == 8'h27, "R10 second byte", blk_rdata, 8'h27);
    clr();
    wait_idle("R10 end");
    chk(nlog == 2 && !nack_log[0] && nack_log[1], "R10 no count, last nack", nlog, 2);

    // R11: single holding register
    buf_mode = 0;
    bw(8'hA5); bw(8'h3C);
    br(v); chk(v == 8'h3C, "R11 holding", v, 8'h3C);
    br(v); chk(v == 8'h3C, "R11 no pointer", v, 8'h3C);

    finish_run();
  end
endmodule